// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Interface

This block sits between the data-space access port of an 8-bit processor and an external static RAM that is wired through a shared address/data bus. Each access is split into two phases. In the first phase the low address byte travels on the shared 8-bit bus and an address strobe pulse tells an external transparent latch to hold it. In the second phase the same bus carries the data byte, framed by an active-low read or write strobe. The high address byte leaves on its own dedicated 8-bit port and stays put for the whole access.

The processor side gives a 16-bit address, write data and single-cycle read or write requests. It gets back read data and a one-cycle completion pulse. An enable input decides who owns the pins. When it is set, the shared bus, the high-address port and the strobes belong to this interface. When it is clear, the pins carry ordinary general-purpose output values supplied from outside. A wait-select input stretches the strobe of an access by a parameterised number of clocks. This gives slower memories more time.

Top module: `xmem_bus_if`

## Requirements
- R1: A request accepted at a clock edge while idle causes, in the next cycle, `ale` high for exactly one clock, with `ad_oe` = all ones and `ad_out` = address bits [7:0].
- R2: In the cycle right after the `ale` cycle, `ale` is low, both strobes are high, and `ad_out` still carries address bits [7:0] with `ad_oe` all ones.
- R3: `hi_out` equals address bits [15:8] in every cycle from the `ale` cycle through the completion cycle.
- R4: A write drives `wr_n` low for 1 clock, or for 1+WAIT_CYC clocks when the wait state is selected. `ad_out` carries the write data with `ad_oe` all ones during those clocks and for the one clock after `wr_n` rises. `rd_n` and `wr_n` are never low together.
- R5: A read drives `rd_n` low for the same lengths as in R4. `ad_oe` is all zeros from the first `rd_n` low cycle through the completion cycle. The read data is taken from `ad_in` on the last clock of `rd_n` low.
- R6: `rsp_done` is high for exactly one clock, in the first cycle with both strobes high after the strobe. On a read, `rsp_rdata` shows the captured byte in that cycle.
- R7: The wait-select input is sampled only at the edge that accepts a request. Changing it later does not change that access.
- R8: Requests that arrive while an access is in progress are ignored. They do not start a new access and do not alter the address or data of the current one.
- R9: When read and write are requested together, the access is a write.
- R10: With the enable clear and no access in progress, `ad_out`, `ad_oe` and `hi_out` follow the general-purpose inputs, `ale` is low and both strobes are high. Requests are ignored: no `rsp_done` and no memory change.
- R11: After reset, and whenever enabled and idle, `ale` is low, both strobes are high, `rsp_done` is low and `ad_oe` is all zeros.
- R12: Clearing the enable during an access does not abort it. The interface keeps the pins until its completion cycle has ended, then hands them to the general-purpose values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xm_en | input | 1 | External-memory enable (pin ownership) |
| xm_wait | input | 1 | Wait-state select, sampled at acceptance |
| req_rd | input | 1 | Read request, one cycle |
| req_wr | input | 1 | Write request, one cycle |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Last read data |
| rsp_done | output | 1 | Completion pulse |
| gpio_ad_out | input | 8 | General-purpose value for the shared bus pins |
| gpio_ad_oe | input | 8 | General-purpose per-pin output enable for the shared bus |
| gpio_hi_out | input | 8 | General-purpose value for the high-address pins |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 8 | Shared bus per-pin output enable |
| ad_in | input | 8 | Shared bus input value |
| hi_out | output | 8 | High-address port |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench runs directed and seeded-random reads and writes against a behavioural latch-plus-memory model. Every cycle of each access is compared with the expected phase waveform.

Several input patterns are chosen because each one separates a specific kind of fault:
- Reads issued with the wait state selected return a decoy byte on the first strobe clock and the true byte only on the last one. This separates sampling on the correct clock from sampling early.
- Wait-select is inverted right after acceptance, which exposes any late sampling of it.
- Read and write are requested together to check which one wins.
- A competing request is held high during an access to check that it is ignored.
- The enable is cleared both while idle and in mid-access. This separates correct pin ownership from a premature hand-back.
- Writes made while disabled are read back after re-enabling, which shows they were ignored.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    typedef enum logic [2:0] {
        XS_IDLE  = 3'd0,
        XS_ALE   = 3'd1,
        XS_AHOLD = 3'd2,
        XS_STRB  = 3'd3,
        XS_RECOV = 3'd4
    } xm_state_e;
endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 wait_sel,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    bus_in,
    output logic                 busy,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic [DATA_W-1:0]    bus_out,
    output logic                 bus_drive,
    output logic [ADDR_W-DATA_W-1:0] hi_addr,
    output logic [DATA_W-1:0]    rdata,
    output logic                 done
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

    typedef struct packed {
        xm_state_e          state;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic               is_wr;
        logic [CNT_W-1:0]   cnt;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    // next-state computation
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            XS_IDLE: begin
                if (en && (rd_req || wr_req)) begin
                    seq_d.state = XS_ALE;
                    seq_d.addr  = addr;
                    seq_d.wdata = wdata;
                    seq_d.is_wr = wr_req;
                    seq_d.cnt   = wait_sel ? CNT_W'(WAIT_CYC) : '0;
                end
            end
            XS_ALE:   seq_d.state = XS_AHOLD;
            XS_AHOLD: seq_d.state = XS_STRB;
            XS_STRB: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = XS_RECOV;
                    if (!seq_q.is_wr) begin
                        seq_d.rdata = bus_in;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            XS_RECOV: seq_d.state = XS_IDLE;
            default:  seq_d.state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: XS_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // phase decode
    logic in_addr_ph, in_data_ph;
    always_comb begin
        in_addr_ph = (seq_q.state == XS_ALE) || (seq_q.state == XS_AHOLD);
        in_data_ph = (seq_q.state == XS_STRB) || (seq_q.state == XS_RECOV);
        busy       = (seq_q.state != XS_IDLE);
        ale        = (seq_q.state == XS_ALE);
        rd_n       = !((seq_q.state == XS_STRB) && !seq_q.is_wr);
        wr_n       = !((seq_q.state == XS_STRB) &&  seq_q.is_wr);
        bus_drive  = in_addr_ph || (in_data_ph && seq_q.is_wr);
        if (in_addr_ph) begin
            bus_out = seq_q.addr[DATA_W-1:0];
        end else if (in_data_ph && seq_q.is_wr) begin
            bus_out = seq_q.wdata;
        end else begin
            bus_out = '0;
        end
        hi_addr = seq_q.addr[ADDR_W-1 -: HI_W];
        rdata   = seq_q.rdata;
        done    = (seq_q.state == XS_RECOV);
    end
endmodule

// File: rtl/xmem_pinmux.sv
module xmem_pinmux #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input  logic              own,
    input  logic [DATA_W-1:0] bus_out,
    input  logic              bus_drive,
    input  logic [HI_W-1:0]   hi_addr,
    input  logic              ale_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] gp_ad_out,
    input  logic [DATA_W-1:0] gp_ad_oe,
    input  logic [HI_W-1:0]   gp_hi_out,
    output logic [DATA_W-1:0] ad_out,
    output logic [DATA_W-1:0] ad_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n
);
    // per-pin selection between memory use and general-purpose use
    for (genvar b = 0; b < DATA_W; b++) begin : g_ad_bit
        assign ad_out[b] = own ? bus_out[b] : gp_ad_out[b];
        assign ad_oe[b]  = own ? bus_drive  : gp_ad_oe[b];
    end
    for (genvar h = 0; h < HI_W; h++) begin : g_hi_bit
        assign hi_out[h] = own ? hi_addr[h] : gp_hi_out[h];
    end
    assign ale  = own & ale_i;
    assign rd_n = ~own | rd_n_i;
    assign wr_n = ~own | wr_n_i;
endmodule

// File: rtl/xmem_bus_if.sv
module xmem_bus_if #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int WAIT_CYC = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xm_en,
    input  logic                     xm_wait,
    input  logic                     req_rd,
    input  logic                     req_wr,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_done,
    input  logic [DATA_W-1:0]        gpio_ad_out,
    input  logic [DATA_W-1:0]        gpio_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] gpio_hi_out,
    output logic [DATA_W-1:0]        ad_out,
    output logic [DATA_W-1:0]        ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic              seq_busy, seq_ale, seq_rd_n, seq_wr_n, seq_drive;
    logic [DATA_W-1:0] seq_bus;
    logic [HI_W-1:0]   seq_hi;
    logic              pins_owned;

    xmem_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WAIT_CYC (WAIT_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (xm_en),
        .wait_sel  (xm_wait),
        .rd_req    (req_rd),
        .wr_req    (req_wr),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .bus_in    (ad_in),
        .busy      (seq_busy),
        .ale       (seq_ale),
        .rd_n      (seq_rd_n),
        .wr_n      (seq_wr_n),
        .bus_out   (seq_bus),
        .bus_drive (seq_drive),
        .hi_addr   (seq_hi),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    // an access in flight keeps the pins even if the enable drops
    assign pins_owned = xm_en | seq_busy;

    xmem_pinmux #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W)
    ) u_mux (
        .own       (pins_owned),
        .bus_out   (seq_bus),
        .bus_drive (seq_drive),
        .hi_addr   (seq_hi),
        .ale_i     (seq_ale),
        .rd_n_i    (seq_rd_n),
        .wr_n_i    (seq_wr_n),
        .gp_ad_out (gpio_ad_out),
        .gp_ad_oe  (gpio_ad_oe),
        .gp_hi_out (gpio_hi_out),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .hi_out    (hi_out),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );
endmodule

// File: rtl/xmem_bus_if_chk.sv
module xmem_bus_if_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ale,
    input logic                     rd_n,
    input logic                     wr_n,
    input logic [DATA_W-1:0]        ad_out,
    input logic [DATA_W-1:0]        ad_oe,
    input logic [ADDR_W-DATA_W-1:0] hi_out,
    input logic                     rsp_done
);
    p_ale_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (rd_n && wr_n && (ad_oe == '1) && (ad_out == $past(ad_out))));

    p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> $stable(hi_out));

    p_no_dual_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ((ad_oe == '1) && $stable(ad_out)));

    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (ad_oe == '0));

    p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rd_n && wr_n && ($past(rd_n) == 1'b0 || $past(wr_n) == 1'b0)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind xmem_bus_if xmem_bus_if_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_xmem_bus_if.sv
`timescale 1ns/1ps
module tb_xmem_bus_if;
    localparam int WAIT_CYC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xm_en = 1'b1, xm_wait = 1'b0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [7:0]  gpio_ad_out = 8'h00, gpio_ad_oe = 8'h00, gpio_hi_out = 8'h00;
    logic [7:0]  ad_out, ad_oe, ad_in, hi_out;
    logic        ale, rd_n, wr_n;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xmem_bus_if #(.WAIT_CYC(WAIT_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .xm_en(xm_en), .xm_wait(xm_wait),
        .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .gpio_ad_out(gpio_ad_out), .gpio_ad_oe(gpio_ad_oe), .gpio_hi_out(gpio_hi_out),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_out(hi_out),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    // external latch + memory model
    logic [7:0] lat = 8'h00;
    logic [7:0] mem [0:1023];
    logic [7:0] exp_mem [0:1023];
    int         rdcnt = 0;
    bit         cur_wait = 1'b0;
    logic [9:0] midx;

    assign midx = {hi_out[1:0], lat};

    always @(posedge clk) begin
        if (ale) lat <= ad_out;
        if (!wr_n) mem[midx] <= ad_out;
        rdcnt <= (!rd_n) ? rdcnt + 1 : 0;
    end

    always_comb begin
        if (!rd_n) ad_in = (cur_wait && rdcnt == 0) ? 8'h5A : mem[midx];
        else       ad_in = 8'hEE;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] mix(input logic [15:0] a);
        return {a[9:8], a[7:0]};
    endfunction

    function automatic logic [7:0] init_val(input int i);
        return 8'(i) ^ 8'h3C ^ 8'(i >> 8);
    endfunction

    task automatic idle_check(input string tag);
        chk(!ale && rd_n && wr_n && !rsp_done && ad_oe == 8'h00, tag,
            {rsp_done, ale, rd_n, wr_n, ad_oe}, {1'b0, 1'b0, 1'b1, 1'b1, 8'h00});
    endtask

    // one access; poke: competing request during access; drop: enable cleared mid-access
    task automatic do_acc(input bit wr, input bit rd, input logic [15:0] a,
                          input logic [7:0] d, input bit w, input bit poke, input bit drop);
        bit is_w;
        int nstb;
        logic [9:0] ix;
        is_w = wr;
        ix = mix(a);
        nstb = w ? 1 + WAIT_CYC : 1;
        @(negedge clk);
        cur_wait = w;
        req_wr = wr; req_rd = rd; req_addr = a; req_wdata = d; xm_wait = w;
        @(posedge clk); #1;
        chk(ale && ad_oe == 8'hFF && ad_out == a[7:0] && rd_n && wr_n, "R1 ale phase",
            {ale, ad_oe, ad_out}, {1'b1, 8'hFF, a[7:0]});
        chk(hi_out == a[15:8], "R3 hi in ale phase", hi_out, a[15:8]);
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
        xm_wait = !w;                       // R7: late change must not matter
        if (drop) xm_en = 1'b0;
        if (poke) begin
            req_rd = 1'b1; req_wr = 1'b1; req_addr = ~a; req_wdata = ~d;
        end
        @(posedge clk); #1;
        chk(!ale && rd_n && wr_n && ad_oe == 8'hFF && ad_out == a[7:0], "R2 address hold",
            {ale, rd_n, wr_n, ad_oe, ad_out}, {1'b0, 1'b1, 1'b1, 8'hFF, a[7:0]});
        for (int k = 0; k < nstb; k++) begin
            @(posedge clk); #1;
            if (is_w)
                chk(!wr_n && rd_n && ad_oe == 8'hFF && ad_out == d, "R4 write strobe",
                    {wr_n, rd_n, ad_oe, ad_out}, {1'b0, 1'b1, 8'hFF, d});
            else
                chk(!rd_n && wr_n && ad_oe == 8'h00, "R5 read strobe",
                    {rd_n, wr_n, ad_oe}, {1'b0, 1'b1, 8'h00});
            chk(hi_out == a[15:8] && !rsp_done, "R3 R8 hi held during strobe",
                {rsp_done, hi_out}, {1'b0, a[15:8]});
        end
        @(posedge clk); #1;
        chk(rd_n && wr_n && rsp_done, "R6 R7 done after strobe",
            {rsp_done, rd_n, wr_n}, {1'b1, 1'b1, 1'b1});
        chk(hi_out == a[15:8], "R3 hi in done cycle", hi_out, a[15:8]);
        if (is_w) begin
            chk(ad_oe == 8'hFF && ad_out == d, "R4 data hold", {ad_oe, ad_out}, {8'hFF, d});
            exp_mem[ix] = d;
        end else begin
            chk(ad_oe == 8'h00, "R5 turnaround", ad_oe, 8'h00);
            chk(rsp_rdata == exp_mem[ix], "R5 R6 read data", rsp_rdata, exp_mem[ix]);
        end
        @(negedge clk);
        req_rd = 1'b0; req_wr = 1'b0;
        @(posedge clk); #1;
        chk(!ale && rd_n && wr_n && !rsp_done, "R6 R8 single done, no new access",
            {rsp_done, ale, rd_n, wr_n}, {1'b0, 1'b0, 1'b1, 1'b1});
        if (drop) begin
            chk(ad_oe == gpio_ad_oe && ad_out == gpio_ad_out && hi_out == gpio_hi_out,
                "R12 pins handed back", {ad_oe, ad_out, hi_out}, {gpio_ad_oe, gpio_ad_out, gpio_hi_out});
            @(negedge clk);
            xm_en = 1'b1;
        end else if (xm_en) begin
            chk(ad_oe == 8'h00, "R11 idle bus released", ad_oe, 8'h00);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = init_val(i);
            exp_mem[i] = init_val(i);
        end
        repeat (3) @(posedge clk);
        #1 idle_check("R11 in reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 idle_check("R11 after reset");

        // directed: plain write/read, both wait settings
        do_acc(1, 0, 16'h0112, 8'hA5, 0, 0, 0);
        do_acc(0, 1, 16'h0112, 8'h00, 0, 0, 0);
        do_acc(1, 0, 16'h02F0, 8'h3C, 1, 0, 0);
        do_acc(0, 1, 16'h02F0, 8'h00, 1, 0, 0);
        do_acc(0, 1, 16'hFFFF, 8'h00, 1, 0, 0);
        do_acc(0, 1, 16'h0000, 8'h00, 0, 0, 0);
        // R9: both requested -> write
        do_acc(1, 1, 16'h0345, 8'h77, 0, 0, 0);
        do_acc(0, 1, 16'h0345, 8'h00, 1, 0, 0);
        // R8: competing request during access
        do_acc(1, 0, 16'h0150, 8'h9E, 1, 1, 0);
        do_acc(0, 1, 16'h0150, 8'h00, 0, 1, 0);
        do_acc(0, 1, 16'hFEAF, 8'h00, 0, 0, 0);  // aliased complement untouched

        // R10: disabled, requests ignored
        @(negedge clk);
        xm_en = 1'b0; gpio_ad_out = 8'hC3; gpio_ad_oe = 8'h0F; gpio_hi_out = 8'h81;
        req_wr = 1'b1; req_addr = 16'h0112; req_wdata = 8'h00;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b1;
        @(negedge clk);
        req_rd = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            chk(!rsp_done && !ale && rd_n && wr_n && ad_out == 8'hC3 && ad_oe == 8'h0F
                && hi_out == 8'h81, "R10 disabled pins",
                {rsp_done, ale, rd_n, wr_n, ad_out, ad_oe, hi_out},
                {1'b0, 1'b0, 1'b1, 1'b1, 8'hC3, 8'h0F, 8'h81});
        end
        @(negedge clk); xm_en = 1'b1;
        do_acc(0, 1, 16'h0112, 8'h00, 0, 0, 0);  // R10: still A5

        // R12: enable dropped mid-access
        do_acc(1, 0, 16'h0220, 8'h4B, 1, 0, 1);
        do_acc(0, 1, 16'h0220, 8'h00, 0, 0, 1);
        do_acc(0, 1, 16'h0220, 8'h00, 1, 0, 0);

        // seeded random mix
        for (int n = 0; n < 80; n++) begin
            logic [15:0] ra;
            logic [7:0]  rd8;
            bit          rw, rwt;
            ra  = 16'($urandom());
            if (n % 2 == 1) ra[9:0] = 10'($urandom_range(0, 15));
            rd8 = 8'($urandom());
            rw  = 1'($urandom());
            rwt = 1'($urandom());
            do_acc(rw, !rw, ra, rd8, rwt, 0, 0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule